// File: doc/BRIEF.md
# MSB-Justified Stereo Serial Audio Port

This block is the digital side of a slave-mode stereo audio link. An external master supplies a frame clock and a bit clock. The port receives both, together with a serial data input, on its own system clock through a short synchronizer chain. On a serial data output it sends one 16-bit two's-complement sample per half-frame. At the same time it assembles one 16-bit sample per half-frame from the serial input. Each sample is MSB first and sits in the first sixteen bit slots after the frame-clock edge, with no one-slot delay. The output MSB appears in response to the frame-clock edge. Each later bit follows a rising bit-clock edge. Any further bit clocks in a half-frame are padding.

On the parallel side, the playback source offers a left and a right word. Both words and the mute input are latched at the start of each left half-frame, and a one-cycle strobe marks that moment. Received words leave as a left and right pair with a single valid pulse. Counting restarts on every frame-clock edge, so the port stays aligned when the number of bit clocks per frame changes.

Top module: `msbj_port`

## Requirements
- R1: While `rst` is high, and after it until the first frame-clock edge, `sdo_o`, `tx_load_o` and `rx_valid_o` are 0 and both received words are 0x0000.
- R2: A high frame clock selects the left channel and a low one selects the right. Bit 15 of the word is on `sdo_o` from the frame-clock edge until the first rising bit-clock edge. Bits 14 down to 0 follow, one after each later rising edge.
- R3: After the sixteenth bit slot of a half-frame, `sdo_o` is 0 until the next frame-clock edge, however many bit clocks follow.
- R4: On each of the first 16 rising bit-clock edges of a half-frame, `sdi_i` is sampled, MSB first. Later rising edges in the same half-frame do not change the received word.
- R5: `mute_i` is sampled at the start of each left half-frame. When it is 1 there, both words sent in that frame are 0x0000. Changes to `mute_i` later in the frame have no effect on that frame.
- R6: `tx_left_i` and `tx_right_i` are latched at the start of each left half-frame, and `tx_load_o` pulses high for exactly one cycle at that point. Later changes to these inputs do not alter the frame being sent.
- R7: Every frame-clock edge restarts the bit count. If a half-frame has fewer than 16 rising edges, its outgoing word is cut short. Its incoming word is discarded, and the next half-frame still starts at its MSB.
- R8: `rx_valid_o` pulses for one cycle after the sixteenth right-channel bit. `rx_left_o` then carries the most recent complete left word and `rx_right_o` the right word just completed. Both outputs hold their values between pulses.
- R9: A rising bit-clock edge that the port sees in the same cycle as a frame-clock edge is discarded by both directions. The first data slot is then the next rising edge.
- R10: Full-scale words 0x7FFF and 0x8000 pass through both directions unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| lrck_i | input | 1 | Frame clock from the master (high = left) |
| sclk_i | input | 1 | Bit clock from the master |
| sdi_i | input | 1 | Serial data into the port |
| sdo_o | output | 1 | Serial data out of the port, MSB-justified |
| mute_i | input | 1 | Mute request, sampled at left half-frame start |
| tx_left_i | input | 16 | Left word to transmit |
| tx_right_i | input | 16 | Right word to transmit |
| tx_load_o | output | 1 | One-cycle pulse when the transmit words are latched |
| rx_left_o | output | 16 | Received left word |
| rx_right_o | output | 16 | Received right word |
| rx_valid_o | output | 1 | One-cycle pulse when a received pair is complete |

## Verification
The frame-clock edge and a rising bit-clock edge can reach the port in the same system-clock cycle. A frame restart and a bit shift then compete in both the transmitter and the receiver. The bench provokes this by raising the bit clock and toggling the frame clock on the same system-clock edge, in directed frames and at random in others. It judges the result at the pins: the MSB must still be the first bit seen on the output at the next real rising edge, and the received pair must come out whole, with the discarded edge counted as no slot at all.

// File: rtl/msbj_pkg.sv
package msbj_pkg;
  localparam int unsigned SAMPLE_W   = 16;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic {
    CH_RIGHT = 1'b0,
    CH_LEFT  = 1'b1
  } chan_e;
endpackage

// File: rtl/msbj_pin_sync.sv
module msbj_pin_sync #(
  parameter int unsigned STAGES = msbj_pkg::SYNC_DEPTH
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lrck_i,
  input  logic                sclk_i,
  input  logic                sdi_i,
  output logic                frame_edge_o,
  output msbj_pkg::chan_e     frame_chan_o,
  output logic                bit_rise_o,
  output logic                sdi_o
);
  localparam int unsigned NPIN   = 3;
  localparam int unsigned P_LRCK = 0;
  localparam int unsigned P_SCLK = 1;
  localparam int unsigned P_SDI  = 2;

  logic [NPIN-1:0] pin_raw;
  logic [NPIN-1:0] chain [STAGES];
  logic            lr_prev;
  logic            sc_prev;
  logic [NPIN-1:0] pin_now;

  assign pin_raw = {sdi_i, sclk_i, lrck_i};

  // all three pins travel through the same depth so they stay aligned
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= pin_raw;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign pin_now = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_prev <= 1'b0;
      sc_prev <= 1'b0;
    end else begin
      lr_prev <= pin_now[P_LRCK];
      sc_prev <= pin_now[P_SCLK];
    end
  end

  assign frame_edge_o = pin_now[P_LRCK] ^ lr_prev;
  assign frame_chan_o = msbj_pkg::chan_e'(pin_now[P_LRCK]);
  assign bit_rise_o   = pin_now[P_SCLK] & ~sc_prev;
  assign sdi_o        = pin_now[P_SDI];

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst) bit_rise_o |=> !bit_rise_o); // R4
endmodule

// File: rtl/msbj_tx.sv
module msbj_tx #(
  parameter int unsigned W = msbj_pkg::SAMPLE_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_edge_i,
  input  msbj_pkg::chan_e frame_chan_i,
  input  logic            bit_rise_i,
  input  logic            mute_i,
  input  logic [W-1:0]    tx_left_i,
  input  logic [W-1:0]    tx_right_i,
  output logic            sdo_o,
  output logic            tx_load_o
);
  import msbj_pkg::*;

  localparam int unsigned CW      = $clog2(W + 1);
  localparam logic [CW-1:0] LAST  = CW'(W - 1);
  localparam logic [CW-1:0] SATUR = CW'(W);

  logic [W-1:0]  hold_r;
  logic [W-1:0]  shreg;
  logic [CW-1:0] cnt;
  logic          sdo_r;
  logic          load_r;
  logic          left_start;
  logic [W-1:0]  left_word;
  logic [W-1:0]  right_word;
  logic [W-1:0]  start_word;

  assign left_start = frame_edge_i && (frame_chan_i == CH_LEFT);
  assign left_word  = mute_i ? '0 : tx_left_i;
  assign right_word = mute_i ? '0 : tx_right_i;
  assign start_word = (frame_chan_i == CH_LEFT) ? left_word : hold_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_r <= '0;
      shreg  <= '0;
      cnt    <= '0;
      sdo_r  <= 1'b0;
      load_r <= 1'b0;
    end else begin
      load_r <= 1'b0;
      if (frame_edge_i) begin
        // frame edge wins over a coincident bit-clock rise
        cnt   <= '0;
        shreg <= start_word;
        sdo_r <= start_word[W-1];
        if (left_start) begin
          hold_r <= right_word;
          load_r <= 1'b1;
        end
      end else if (bit_rise_i) begin
        if (cnt < LAST) begin
          shreg <= {shreg[W-2:0], 1'b0};
          sdo_r <= shreg[W-2];
          cnt   <= cnt + 1'b1;
        end else begin
          sdo_r <= 1'b0;
          if (cnt != SATUR) cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign sdo_o     = sdo_r;
  assign tx_load_o = load_r;

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst) (bit_rise_i && !frame_edge_i && cnt >= LAST) |=> !sdo_o); // R3
  AST_MUTE_SILENT: assert property (@(posedge clk) disable iff (rst) (left_start && mute_i) |=> !sdo_o); // R5
  AST_LOAD_AT_LEFT: assert property (@(posedge clk) disable iff (rst) tx_load_o |-> $past(left_start)); // R6
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (rst) tx_load_o |=> !tx_load_o); // R6
  AST_QUIET_BETWEEN: assert property (@(posedge clk) disable iff (rst) (!bit_rise_i && !frame_edge_i) |=> $stable(sdo_o)); // R2
endmodule

// File: rtl/msbj_rx.sv
module msbj_rx #(
  parameter int unsigned W = msbj_pkg::SAMPLE_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_edge_i,
  input  msbj_pkg::chan_e frame_chan_i,
  input  logic            bit_rise_i,
  input  logic            sdi_i,
  output logic [W-1:0]    rx_left_o,
  output logic [W-1:0]    rx_right_o,
  output logic            rx_valid_o
);
  import msbj_pkg::*;

  localparam int unsigned CW     = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic [CW-1:0] cnt;
  logic [W-1:0]  shreg;
  logic [W-1:0]  shifted;
  logic [W-1:0]  pend_left;
  logic [W-1:0]  left_r;
  logic [W-1:0]  right_r;
  logic          valid_r;
  logic          take_bit;

  assign shifted  = {shreg[W-2:0], sdi_i};
  assign take_bit = bit_rise_i && !frame_edge_i && (cnt < FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      shreg     <= '0;
      pend_left <= '0;
      left_r    <= '0;
      right_r   <= '0;
      valid_r   <= 1'b0;
    end else begin
      valid_r <= 1'b0;
      if (frame_edge_i) begin
        cnt <= '0;
      end else if (take_bit) begin
        shreg <= shifted;
        cnt   <= cnt + 1'b1;
        if (cnt == LAST) begin
          if (frame_chan_i == CH_LEFT) begin
            pend_left <= shifted;
          end else begin
            left_r  <= pend_left;
            right_r <= shifted;
            valid_r <= 1'b1;
          end
        end
      end
    end
  end

  assign rx_left_o  = left_r;
  assign rx_right_o = right_r;
  assign rx_valid_o = valid_r;

  AST_VALID_AFTER_BIT: assert property (@(posedge clk) disable iff (rst) rx_valid_o |-> $past(bit_rise_i && !frame_edge_i)); // R8
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst) rx_valid_o |=> !rx_valid_o); // R8
  AST_WORDS_HELD: assert property (@(posedge clk) disable iff (rst) !rx_valid_o |-> ($stable(rx_left_o) && $stable(rx_right_o))); // R8
  AST_EDGE_NO_VALID: assert property (@(posedge clk) disable iff (rst) frame_edge_i |=> !rx_valid_o); // R9
endmodule

// File: rtl/msbj_port.sv
module msbj_port #(
  parameter int unsigned W      = msbj_pkg::SAMPLE_W,
  parameter int unsigned STAGES = msbj_pkg::SYNC_DEPTH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lrck_i,
  input  logic         sclk_i,
  input  logic         sdi_i,
  output logic         sdo_o,
  input  logic         mute_i,
  input  logic [W-1:0] tx_left_i,
  input  logic [W-1:0] tx_right_i,
  output logic         tx_load_o,
  output logic [W-1:0] rx_left_o,
  output logic [W-1:0] rx_right_o,
  output logic         rx_valid_o
);
  import msbj_pkg::*;

  logic  frame_edge;
  chan_e frame_chan;
  logic  bit_rise;
  logic  sdi_s;

  msbj_pin_sync #(.STAGES(STAGES)) u_sync (
    .clk          (clk),
    .rst          (rst),
    .lrck_i       (lrck_i),
    .sclk_i       (sclk_i),
    .sdi_i        (sdi_i),
    .frame_edge_o (frame_edge),
    .frame_chan_o (frame_chan),
    .bit_rise_o   (bit_rise),
    .sdi_o        (sdi_s)
  );

  msbj_tx #(.W(W)) u_tx (
    .clk          (clk),
    .rst          (rst),
    .frame_edge_i (frame_edge),
    .frame_chan_i (frame_chan),
    .bit_rise_i   (bit_rise),
    .mute_i       (mute_i),
    .tx_left_i    (tx_left_i),
    .tx_right_i   (tx_right_i),
    .sdo_o        (sdo_o),
    .tx_load_o    (tx_load_o)
  );

  msbj_rx #(.W(W)) u_rx (
    .clk          (clk),
    .rst          (rst),
    .frame_edge_i (frame_edge),
    .frame_chan_i (frame_chan),
    .bit_rise_i   (bit_rise),
    .sdi_i        (sdi_s),
    .rx_left_o    (rx_left_o),
    .rx_right_o   (rx_right_o),
    .rx_valid_o   (rx_valid_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!sdo_o && !tx_load_o && !rx_valid_o)); // R1
endmodule

// File: tb/msbj_port_bench.sv
module msbj_port_bench;
  localparam int W = 16;
  localparam int H = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         lrck = 1'b0;
  logic         sclk = 1'b0;
  logic         sdi = 1'b0;
  logic         mute = 1'b0;
  logic [W-1:0] txl = '0;
  logic [W-1:0] txr = '0;
  logic         sdo;
  logic         tx_load;
  logic [W-1:0] rxl;
  logic [W-1:0] rxr;
  logic         rx_valid;

  int checks = 0;
  int errors = 0;
  int valid_cnt = 0;
  int load_cnt = 0;
  logic [W-1:0] exp_pend_left = '0;
  logic [W-1:0] last_rxr = '0;
  logic [W-1:0] last_rxl = '0;

  always #5 clk = ~clk;

  msbj_port u_msbj_port (
    .clk(clk), .rst(rst), .lrck_i(lrck), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .mute_i(mute), .tx_left_i(txl), .tx_right_i(txr),
    .tx_load_o(tx_load), .rx_left_o(rxl), .rx_right_o(rxr), .rx_valid_o(rx_valid)
  );

  always @(negedge clk) begin
    if (rx_valid) valid_cnt++;
    if (tx_load)  load_cnt++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] topmask(input int n);
    if (n >= W) return '1;
    return ~({W{1'b1}} >> n);
  endfunction

  // one half-frame acting as the far-end master
  task automatic half(input bit lv, input logic [W-1:0] din, input int n,
                      input bit coin, output logic [W-1:0] dout, output bit pad_bad);
    dout = '0;
    pad_bad = 1'b0;
    @(negedge clk);
    lrck = lv;
    sdi  = din[W-1];
    if (coin) begin
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    for (int k = 0; k < n; k++) begin
      repeat (H) @(negedge clk);
      if (k < W) dout[W-1-k] = sdo;
      else if (sdo !== 1'b0) pad_bad = 1'b1;
      if (k == 0 && lv) begin
        // the words and mute were latched at the frame edge; disturb them now
        txl  = 16'($urandom);
        txr  = 16'($urandom);
        mute = ~mute;
      end
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
      if (k + 1 < W) sdi = din[W-2-k];
      else           sdi = 1'($urandom);
    end
  endtask

  task automatic frame(input logic [W-1:0] wl, input logic [W-1:0] wr, input bit mt,
                       input logic [W-1:0] sl, input logic [W-1:0] sr,
                       input int nl, input int nr, input bit cl, input bit cr,
                       input string rtag);
    logic [W-1:0] gl, gr, el, er, ml, mr;
    bit pl, pr;
    int lc, vc;
    txl = wl; txr = wr; mute = mt;
    lc = load_cnt; vc = valid_cnt;
    half(1'b1, sl, nl, cl, gl, pl);
    half(1'b0, sr, nr, cr, gr, pr);
    el = mt ? '0 : wl;
    er = mt ? '0 : wr;
    ml = topmask(nl);
    mr = topmask(nr);
    chk((gl & ml) == (el & ml), rtag, "sdo left word", 32'(gl & ml), 32'(el & ml));
    chk((gr & mr) == (er & mr), rtag, "sdo right word", 32'(gr & mr), 32'(er & mr));
    chk(!pl && !pr, "R3", "padding slots zero", 32'({pl, pr}), 32'd0);
    chk(load_cnt == lc + 1, "R6", "tx_load pulses per frame", 32'(load_cnt - lc), 32'd1);
    if (nl >= W) exp_pend_left = sl;
    if (nr >= W) begin
      last_rxl = exp_pend_left;
      last_rxr = sr;
      chk(valid_cnt == vc + 1, "R8", "rx_valid pulses per frame", 32'(valid_cnt - vc), 32'd1);
    end else begin
      chk(valid_cnt == vc, "R7", "no valid for short right half", 32'(valid_cnt - vc), 32'd0);
    end
    chk(rxl == last_rxl, (rtag == "R2") ? "R4" : rtag, "rx left word", 32'(rxl), 32'(last_rxl));
    chk(rxr == last_rxr, (rtag == "R2") ? "R4" : rtag, "rx right word", 32'(rxr), 32'(last_rxr));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(sdo == 1'b0, "R1", "sdo after reset", 32'(sdo), 32'd0);
    chk(!tx_load && !rx_valid, "R1", "strobes after reset", 32'({tx_load, rx_valid}), 32'd0);
    chk(rxl == '0 && rxr == '0, "R1", "rx words after reset", {rxl, rxr}, 32'd0);

    // R2/R4: plain 16+16 frame
    frame(16'hA5C3, 16'h3C5A, 1'b0, 16'h1234, 16'hFEDC, 16, 16, 1'b0, 1'b0, "R2");
    // R3: long halves with padding
    frame(16'hFFFF, 16'hFFFF, 1'b0, 16'hBEEF, 16'hCAFE, 40, 40, 1'b0, 1'b0, "R3");
    // R5: mute
    frame(16'h7777, 16'h8888, 1'b1, 16'h0F0F, 16'hF0F0, 20, 20, 1'b0, 1'b0, "R5");
    // R10: full scale both directions
    frame(16'h7FFF, 16'h8000, 1'b0, 16'h8000, 16'h7FFF, 16, 24, 1'b0, 1'b0, "R10");
    // R9: bit-clock rise coinciding with frame edge
    frame(16'h6B1D, 16'h92E4, 1'b0, 16'h4C21, 16'h3AA5, 18, 18, 1'b1, 1'b1, "R9");
    // R7: short right half, then a short left half, then recovery
    frame(16'h1111, 16'h2222, 1'b0, 16'h5555, 16'h6666, 16, 10, 1'b0, 1'b0, "R7");
    frame(16'h0F1E, 16'hE1F0, 1'b0, 16'h9999, 16'h7A7A, 9, 16, 1'b0, 1'b0, "R7");
    frame(16'hC001, 16'h8003, 1'b0, 16'h2468, 16'h1357, 32, 32, 1'b0, 1'b0, "R7");

    for (int i = 0; i < 30; i++) begin
      frame(16'($urandom), 16'($urandom), ($urandom % 6) == 0,
            16'($urandom), 16'($urandom),
            16 + int'($urandom % 25), 16 + int'($urandom % 25),
            ($urandom % 8) == 0, ($urandom % 8) == 0, "R2");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule